// File: doc/BRIEF.md
# Load-Linked Reservation Unit

This unit executes the load-linked word instruction for one processor and owns that processor's single atomic read-modify-write reservation. An instruction word and the base register value enter together. The unit decodes the instruction and forms the effective address from the base value and the sign-extended 16-bit displacement. A misaligned address produces a one-cycle address-error pulse. An aligned address produces a word load request on a valid/ready port. The returned word is handed back as a one-cycle write-back to the destination register index taken from the instruction.

When the write-back occurs, the unit sets a link flag and records the reserved word address. A companion store-conditional request is answered one cycle later with pass or fail. A request passes only while the link is set and its word address matches the reservation. The link is then cleared whatever the result. The link is also cleared by a snooped write to the reserved word from another agent, by an exception-return pulse, and by reset. A load-linked observed on the snoop port from another processor never disturbs the link. Address translation, the cache and the register file sit outside the unit.

Top module: `llsc_reserve_unit`

## Requirements
- R1: An instruction is treated as load-linked only when bits [31:26] equal 110000. Bits [20:16] give the destination index and bits [15:0] give the signed displacement. An accepted instruction with any other opcode produces neither a load request nor an address error.
- R2: For an aligned load-linked, `ld_req_valid` rises in the cycle after acceptance. `ld_req_addr` then equals the base value plus the sign-extended displacement, modulo 2^32. Both hold steady until `ld_req_ready` is seen high.
- R3: If bit 1 or bit 0 of the effective address is set, `addr_err` is high for exactly the one cycle after acceptance. No load request is issued, and the link and the reservation keep their previous values.
- R4: In the cycle after `ld_rsp_valid`, `wb_valid` is high for exactly one cycle. In that cycle `wb_data` equals the response word and `wb_reg` equals bits [20:16] of the instruction.
- R5: In the cycle `wb_valid` is high, `link_bit` is 1 and the reservation holds the word address of that load.
- R6: A later load-linked replaces any reservation still held. After that, only the newer word address can pass.
- R7: A store-conditional pulse gives `sc_done` high one cycle later. `sc_pass` is 1 only if the link was set and bits [31:2] of `sc_addr` equal the reserved word address. The link reads 0 afterwards whether or not the request passed.
- R8: A snoop with `snoop_write` = 0 is a load-linked by another processor. It never clears the link, even when it targets the reserved word.
- R9: A snoop with `snoop_write` = 1 to any byte of the reserved word clears the link. A snooped write to any other word leaves the link set.
- R10: An `eret_pulse` clears the link.
- R11: A reservation with no following store-conditional stays valid across idle cycles until it is replaced or cleared.
- R12: After reset, `link_bit`, `ld_req_valid`, `addr_err`, `wb_valid` and `sc_done` are 0 and `instr_ready` is 1.
- R13: `instr_ready` is 0 from the cycle after an aligned load-linked is accepted until its write-back cycle. It is 1 again in the write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_word | input | 32 | Instruction word |
| base_sel | output | 5 | Base register index (bits [25:21]) for the register file read |
| base_val | input | 32 | Base register value |
| addr_err | output | 1 | Misaligned load-linked address pulse |
| ld_req_valid | output | 1 | Word load request |
| ld_req_ready | input | 1 | Load request accepted |
| ld_req_addr | output | 32 | Load word address |
| ld_rsp_valid | input | 1 | Load data returned (one cycle) |
| ld_rsp_data | input | 32 | Loaded word |
| wb_valid | output | 1 | Register write-back strobe |
| wb_reg | output | 5 | Destination register index |
| wb_data | output | 32 | Write-back data |
| link_bit | output | 1 | Reservation active |
| sc_valid | input | 1 | Store-conditional check request |
| sc_addr | input | 32 | Store-conditional address |
| sc_done | output | 1 | Store-conditional result valid |
| sc_pass | output | 1 | 1 = pass, 0 = fail |
| snoop_valid | input | 1 | Access from another agent observed |
| snoop_write | input | 1 | 1 = write, 0 = load-linked |
| snoop_addr | input | 32 | Snooped address |
| eret_pulse | input | 1 | Exception return |

## Verification
The address path is exercised by a sweep over every combination of the low two bits of base and displacement, each with a positive and a negative displacement. This separates carry into bits [1:0] from plain bitwise combination, and it checks sign extension across a word boundary. Before each swept load, a reservation is placed on a fixed anchor word. A store-conditional to the anchor afterwards must pass exactly for the misaligned cases. That result shows whether a misaligned access disturbed the reservation and whether an aligned one replaced it. Targeted sequences then separate snooped writes from snooped load-linked accesses, writes to a byte inside the reserved word from writes to the neighbouring word, exception return, an abandoned reservation, a store-conditional without a link, and foreign opcodes.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   localparam int INSTR_W = 32;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_REQ  = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;

   function automatic logic [31:0] sext16(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction
endpackage

// File: rtl/ll_decoder.sv
module ll_decoder #(
   parameter int          DATA_W     = 32,
   parameter int          OFF_W      = 16,
   parameter int          IDX_W      = 5,
   parameter int          OPC_W      = 6,
   parameter logic [5:0]  LL_OPCODE  = 6'b110000,
   parameter int          ALIGN_BITS = 2
) (
   input  logic [llsc_pkg::INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]            base_val,
   output logic                         is_ll,
   output logic [IDX_W-1:0]             rt_idx,
   output logic [IDX_W-1:0]             base_idx,
   output logic [DATA_W-1:0]            eff_addr,
   output logic                         misaligned
);
   localparam int IW      = llsc_pkg::INSTR_W;
   localparam int OPC_LSB = IW - OPC_W;
   localparam int BASE_LSB = OPC_LSB - IDX_W;
   localparam int RT_LSB  = BASE_LSB - IDX_W;

   logic [OFF_W-1:0]  disp;
   logic [DATA_W-1:0] disp_ext;

   assign disp     = instr[OFF_W-1:0];
   assign disp_ext = {{(DATA_W-OFF_W){disp[OFF_W-1]}}, disp};
   assign is_ll    = (instr[IW-1:OPC_LSB] == LL_OPCODE[OPC_W-1:0]);
   assign rt_idx   = instr[RT_LSB +: IDX_W];
   assign base_idx = instr[BASE_LSB +: IDX_W];
   assign eff_addr = base_val + disp_ext;

   generate
      if (ALIGN_BITS > 0) begin : g_chk
         assign misaligned = |eff_addr[ALIGN_BITS-1:0];
      end else begin : g_nochk
         assign misaligned = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ll_load_seq.sv
module ll_load_seq #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              is_ll,
   input  logic              misaligned,
   input  logic [DATA_W-1:0] eff_addr,
   input  logic [IDX_W-1:0]  rt_idx,
   output logic              idle,
   output logic              addr_err,
   output logic              ld_req_valid,
   input  logic              ld_req_ready,
   output logic [DATA_W-1:0] ld_req_addr,
   input  logic              ld_rsp_valid,
   input  logic [DATA_W-1:0] ld_rsp_data,
   output logic              wb_valid,
   output logic [IDX_W-1:0]  wb_reg,
   output logic [DATA_W-1:0] wb_data,
   output logic              set_link,
   output logic [DATA_W-1:0] set_addr
);
   import llsc_pkg::*;

   seq_state_e        st_q;
   logic [DATA_W-1:0] addr_q;
   logic [IDX_W-1:0]  rt_q;
   logic              err_q;
   logic              wbv_q;
   logic [IDX_W-1:0]  wbr_q;
   logic [DATA_W-1:0] wbd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         addr_q <= '0;
         rt_q   <= '0;
         err_q  <= 1'b0;
         wbv_q  <= 1'b0;
         wbr_q  <= '0;
         wbd_q  <= '0;
      end else begin
         err_q <= 1'b0;
         wbv_q <= 1'b0;
         unique case (st_q)
            SEQ_IDLE: begin
               if (accept && is_ll) begin
                  if (misaligned) begin
                     err_q <= 1'b1;
                  end else begin
                     addr_q <= eff_addr;
                     rt_q   <= rt_idx;
                     st_q   <= SEQ_REQ;
                  end
               end
            end
            SEQ_REQ: begin
               if (ld_req_ready) st_q <= SEQ_WAIT;
            end
            SEQ_WAIT: begin
               if (ld_rsp_valid) begin
                  wbv_q <= 1'b1;
                  wbr_q <= rt_q;
                  wbd_q <= ld_rsp_data;
                  st_q  <= SEQ_IDLE;
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign idle         = (st_q == SEQ_IDLE);
   assign addr_err     = err_q;
   assign ld_req_valid = (st_q == SEQ_REQ);
   assign ld_req_addr  = addr_q;
   assign wb_valid     = wbv_q;
   assign wb_reg       = wbr_q;
   assign wb_data      = wbd_q;
   assign set_link     = (st_q == SEQ_WAIT) && ld_rsp_valid;
   assign set_addr     = addr_q;
endmodule

// File: rtl/llsc_link_tracker.sv
module llsc_link_tracker #(
   parameter int DATA_W       = 32,
   parameter int RESV_LSB     = 2,
   parameter bit COMPARE_FULL = 1'b1,
   parameter int TAG_W        = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_link,
   input  logic [DATA_W-1:0] set_addr,
   input  logic              sc_valid,
   input  logic [DATA_W-1:0] sc_addr,
   input  logic              snoop_valid,
   input  logic              snoop_write,
   input  logic [DATA_W-1:0] snoop_addr,
   input  logic              eret_pulse,
   output logic              link,
   output logic              sc_done,
   output logic              sc_pass
);
   localparam int IDX_BITS = DATA_W - RESV_LSB;
   localparam int KEY_W    = COMPARE_FULL ? IDX_BITS : TAG_W;

   logic [KEY_W-1:0] resv_q;
   logic [KEY_W-1:0] key_set, key_sc, key_snp;
   logic             link_q, done_q, pass_q;
   logic             clr;

   generate
      if (COMPARE_FULL) begin : g_full
         assign key_set = set_addr[DATA_W-1:RESV_LSB];
         assign key_sc  = sc_addr[DATA_W-1:RESV_LSB];
         assign key_snp = snoop_addr[DATA_W-1:RESV_LSB];
         logic unused_lo;
         assign unused_lo = ^{set_addr[RESV_LSB-1:0], sc_addr[RESV_LSB-1:0],
                              snoop_addr[RESV_LSB-1:0]};
      end else begin : g_tag
         assign key_set = set_addr[RESV_LSB +: TAG_W];
         assign key_sc  = sc_addr[RESV_LSB +: TAG_W];
         assign key_snp = snoop_addr[RESV_LSB +: TAG_W];
         logic unused_rest;
         assign unused_rest = ^{set_addr, sc_addr, snoop_addr};
      end
   endgenerate

   assign clr = sc_valid || eret_pulse ||
                (snoop_valid && snoop_write && (key_snp == resv_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= 1'b0;
         resv_q <= '0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         done_q <= sc_valid;
         pass_q <= sc_valid && link_q && (key_sc == resv_q);
         if (set_link) begin
            link_q <= 1'b1;
            resv_q <= key_set;
         end else if (clr) begin
            link_q <= 1'b0;
         end
      end
   end

   assign link    = link_q;
   assign sc_done = done_q;
   assign sc_pass = pass_q;
endmodule

// File: rtl/llsc_reserve_unit.sv
module llsc_reserve_unit #(
   parameter int         DATA_W       = 32,
   parameter int         OFF_W        = 16,
   parameter int         IDX_W        = 5,
   parameter int         OPC_W        = 6,
   parameter logic [5:0] LL_OPCODE    = 6'b110000,
   parameter int         WORD_BYTES   = 4,
   parameter bit         COMPARE_FULL = 1'b1,
   parameter int         TAG_W        = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         instr_valid,
   output logic                         instr_ready,
   input  logic [llsc_pkg::INSTR_W-1:0] instr_word,
   output logic [IDX_W-1:0]             base_sel,
   input  logic [DATA_W-1:0]            base_val,
   output logic                         addr_err,
   output logic                         ld_req_valid,
   input  logic                         ld_req_ready,
   output logic [DATA_W-1:0]            ld_req_addr,
   input  logic                         ld_rsp_valid,
   input  logic [DATA_W-1:0]            ld_rsp_data,
   output logic                         wb_valid,
   output logic [IDX_W-1:0]             wb_reg,
   output logic [DATA_W-1:0]            wb_data,
   output logic                         link_bit,
   input  logic                         sc_valid,
   input  logic [DATA_W-1:0]            sc_addr,
   output logic                         sc_done,
   output logic                         sc_pass,
   input  logic                         snoop_valid,
   input  logic                         snoop_write,
   input  logic [DATA_W-1:0]            snoop_addr,
   input  logic                         eret_pulse
);
   localparam int ALIGN_BITS = $clog2(WORD_BYTES);

   generate
      if (OFF_W > DATA_W)
         $error("displacement wider than data path");
      if (OFF_W + 2*IDX_W + OPC_W != llsc_pkg::INSTR_W)
         $error("instruction fields do not fill the word");
      if ((1 << ALIGN_BITS) != WORD_BYTES)
         $error("word size must be a power of two");
      if (!COMPARE_FULL && (TAG_W < 1 || TAG_W > DATA_W - ALIGN_BITS))
         $error("tag width out of range");
   endgenerate

   logic              is_ll, misaligned, idle, set_link;
   logic [IDX_W-1:0]  rt_idx;
   logic [DATA_W-1:0] eff_addr, set_addr;

   ll_decoder #(
      .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .OPC_W(OPC_W),
      .LL_OPCODE(LL_OPCODE), .ALIGN_BITS(ALIGN_BITS)
   ) dec_i (
      .instr(instr_word), .base_val(base_val), .is_ll(is_ll),
      .rt_idx(rt_idx), .base_idx(base_sel), .eff_addr(eff_addr),
      .misaligned(misaligned)
   );

   ll_load_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .accept(instr_valid && idle),
      .is_ll(is_ll), .misaligned(misaligned), .eff_addr(eff_addr),
      .rt_idx(rt_idx), .idle(idle), .addr_err(addr_err),
      .ld_req_valid(ld_req_valid), .ld_req_ready(ld_req_ready),
      .ld_req_addr(ld_req_addr), .ld_rsp_valid(ld_rsp_valid),
      .ld_rsp_data(ld_rsp_data), .wb_valid(wb_valid), .wb_reg(wb_reg),
      .wb_data(wb_data), .set_link(set_link), .set_addr(set_addr)
   );

   llsc_link_tracker #(
      .DATA_W(DATA_W), .RESV_LSB(ALIGN_BITS),
      .COMPARE_FULL(COMPARE_FULL), .TAG_W(TAG_W)
   ) trk_i (
      .clk(clk), .rst_n(rst_n), .set_link(set_link), .set_addr(set_addr),
      .sc_valid(sc_valid), .sc_addr(sc_addr), .snoop_valid(snoop_valid),
      .snoop_write(snoop_write), .snoop_addr(snoop_addr),
      .eret_pulse(eret_pulse), .link(link_bit), .sc_done(sc_done),
      .sc_pass(sc_pass)
   );

   assign instr_ready = idle;
endmodule

// File: rtl/llsc_reserve_checker.sv
module llsc_reserve_checker #(
   parameter int         DATA_W    = 32,
   parameter int         OFF_W     = 16,
   parameter logic [5:0] LL_OPCODE = 6'b110000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic              instr_ready,
   input logic [31:0]       instr_word,
   input logic [DATA_W-1:0] base_val,
   input logic              addr_err,
   input logic              ld_req_valid,
   input logic              ld_req_ready,
   input logic [DATA_W-1:0] ld_req_addr,
   input logic              ld_rsp_valid,
   input logic [DATA_W-1:0] ld_rsp_data,
   input logic              wb_valid,
   input logic [DATA_W-1:0] wb_data,
   input logic              link_bit,
   input logic              sc_valid,
   input logic              sc_done,
   input logic              sc_pass,
   input logic              snoop_valid,
   input logic              snoop_write,
   input logic              eret_pulse
);
   logic              take, ll_op;
   logic [DATA_W-1:0] ea_chk;

   assign take   = instr_valid && instr_ready;
   assign ll_op  = (instr_word[31:26] == LL_OPCODE);
   assign ea_chk = base_val + {{(DATA_W-OFF_W){instr_word[OFF_W-1]}}, instr_word[OFF_W-1:0]};

   assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      take && !ll_op |=> !ld_req_valid && !addr_err);

   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req_valid && !ld_req_ready |=> ld_req_valid && $stable(ld_req_addr));

   assert_misalign_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take && ll_op && (ea_chk[1:0] != 2'b00) |=> addr_err && !ld_req_valid);

   assert_wb_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rsp_valid && !ld_req_valid && !instr_ready |=> wb_valid && (wb_data == $past(ld_rsp_data)));

   assert_wb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);

   assert_link_on_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> link_bit);

   assert_sc_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_done && !wb_valid |-> !link_bit);

   assert_sc_needs_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_valid |=> sc_done && (!sc_pass || $past(link_bit)));

   assert_snoop_ll_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      link_bit && snoop_valid && !snoop_write && !sc_valid && !eret_pulse |=> link_bit);

   assert_eret_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eret_pulse && !wb_valid && !(ld_rsp_valid && !ld_req_valid && !instr_ready) |=> !link_bit);
endmodule

bind llsc_reserve_unit llsc_reserve_checker #(
   .DATA_W(DATA_W), .OFF_W(OFF_W), .LL_OPCODE(LL_OPCODE)
) chk_i (.*);

// File: tb/llsc_reserve_unit_tb.sv
module llsc_reserve_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic        instr_ready;
   logic [31:0] instr_word = '0;
   logic [4:0]  base_sel;
   logic [31:0] base_val = '0;
   logic        addr_err, ld_req_valid;
   logic        ld_req_ready = 1'b0;
   logic [31:0] ld_req_addr;
   logic        ld_rsp_valid = 1'b0;
   logic [31:0] ld_rsp_data = '0;
   logic        wb_valid;
   logic [4:0]  wb_reg;
   logic [31:0] wb_data;
   logic        link_bit;
   logic        sc_valid = 1'b0;
   logic [31:0] sc_addr = '0;
   logic        sc_done, sc_pass;
   logic        snoop_valid = 1'b0, snoop_write = 1'b0;
   logic [31:0] snoop_addr = '0;
   logic        eret_pulse = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   llsc_reserve_unit dut_i (.*);

   localparam logic [5:0]  OP_LL  = 6'b110000;
   localparam logic [31:0] ANCHOR = 32'h2000_0040;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a ^ 32'h5A5A_0000) + 32'd17;
   endfunction

   task automatic do_ll(input logic [5:0] op, input logic [31:0] base, input logic [15:0] off,
                        input logic [4:0] rt, input int delay);
      logic [31:0] ea;
      bit          prev_link;
      ea = base + {{16{off[15]}}, off};
      prev_link = link_bit;
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = {op, 5'd3, rt, off};
      base_val    = base;
      @(negedge clk);
      instr_valid = 1'b0;
      if (op != OP_LL) begin
         check(!ld_req_valid && !addr_err, "R1", {ld_req_valid, addr_err}, 0);
         return;
      end
      if (ea[1:0] != 2'b00) begin
         check(addr_err && !ld_req_valid, "R3", {addr_err, ld_req_valid}, 2'b10);
         check(link_bit == prev_link, "R3", link_bit, prev_link);
         @(negedge clk);
         check(!addr_err, "R3", addr_err, 0);
         return;
      end
      check(ld_req_valid && ld_req_addr == ea, "R2", ld_req_addr, ea);
      check(!instr_ready, "R13", instr_ready, 0);
      for (int d = 0; d < delay; d++) begin
         @(negedge clk);
         check(ld_req_valid && ld_req_addr == ea, "R2", ld_req_addr, ea);
      end
      ld_req_ready = 1'b1;
      @(negedge clk);
      ld_req_ready = 1'b0;
      check(!ld_req_valid && !instr_ready, "R13", {ld_req_valid, instr_ready}, 0);
      ld_rsp_valid = 1'b1;
      ld_rsp_data  = mem_word(ea);
      @(negedge clk);
      ld_rsp_valid = 1'b0;
      check(wb_valid && wb_data == mem_word(ea) && wb_reg == rt, "R4", wb_data, mem_word(ea));
      check(link_bit, "R5", link_bit, 1);
      check(instr_ready, "R13", instr_ready, 1);
      @(negedge clk);
      check(!wb_valid, "R4", wb_valid, 0);
   endtask

   task automatic do_sc(input logic [31:0] a, input bit exp, input string req);
      @(negedge clk);
      sc_valid = 1'b1;
      sc_addr  = a;
      @(negedge clk);
      sc_valid = 1'b0;
      check(sc_done && sc_pass == exp, req, sc_pass, exp);
      check(!link_bit, "R7", link_bit, 0);
   endtask

   task automatic do_snoop(input logic [31:0] a, input bit wr);
      @(negedge clk);
      snoop_valid = 1'b1;
      snoop_write = wr;
      snoop_addr  = a;
      @(negedge clk);
      snoop_valid = 1'b0;
      snoop_write = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!link_bit && !ld_req_valid && !addr_err && !wb_valid && !sc_done && instr_ready,
            "R12", {link_bit, ld_req_valid, addr_err, wb_valid, sc_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: no link, store-conditional fails
      do_sc(ANCHOR, 1'b0, "R7");

      // R1: foreign opcodes do nothing, even with misaligned address
      do_ll(6'b100011, 32'h1000_0001, 16'h0000, 5'd4, 0);
      do_ll(6'b111000, 32'h1000_0000, 16'h0010, 5'd4, 0);
      check(!link_bit, "R1", link_bit, 0);

      // R2/R3/R6 sweep: low-bit combinations, both displacement signs
      for (int b = 0; b < 4; b++) begin
         for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 2; s++) begin
               logic [31:0] base;
               logic [15:0] off;
               logic [31:0] ea;
               base = 32'h1000_0100 + 32'(b);
               off  = (s != 0) ? 16'hFFE0 + 16'(o) : 16'h0020 + 16'(o);
               ea   = base + {{16{off[15]}}, off};
               do_ll(OP_LL, ANCHOR, 16'h0000, 5'd1, 0);
               do_ll(OP_LL, base, off, 5'(b*4+o+s*16), (b + o) % 3);
               if (ea[1:0] != 2'b00) begin
                  do_sc(ANCHOR, 1'b1, "R3");
               end else begin
                  do_sc(ANCHOR, 1'b0, "R6");
               end
            end
         end
      end

      // R6: newer reservation passes
      do_ll(OP_LL, 32'h3000_0000, 16'h0008, 5'd7, 1);
      do_ll(OP_LL, 32'h3000_0000, 16'h0010, 5'd8, 0);
      do_sc(32'h3000_0010, 1'b1, "R6");

      // R8: foreign load-linked to reserved word keeps link
      do_ll(OP_LL, ANCHOR, 16'h0000, 5'd2, 0);
      do_snoop(ANCHOR, 1'b0);
      check(link_bit, "R8", link_bit, 1);
      do_sc(ANCHOR + 32'd3, 1'b1, "R8");

      // R9: write to another word keeps, write to a byte of reserved word clears
      do_ll(OP_LL, ANCHOR, 16'h0000, 5'd2, 0);
      do_snoop(ANCHOR + 32'd4, 1'b1);
      check(link_bit, "R9", link_bit, 1);
      do_snoop(ANCHOR + 32'd2, 1'b1);
      check(!link_bit, "R9", link_bit, 0);
      do_sc(ANCHOR, 1'b0, "R9");

      // R10: exception return clears
      do_ll(OP_LL, ANCHOR, 16'h0000, 5'd2, 0);
      @(negedge clk);
      eret_pulse = 1'b1;
      @(negedge clk);
      eret_pulse = 1'b0;
      check(!link_bit, "R10", link_bit, 0);
      do_sc(ANCHOR, 1'b0, "R10");

      // R11: abandoned reservation persists
      do_ll(OP_LL, 32'h4000_0000, 16'hFFFC, 5'd9, 0);
      repeat (50) @(negedge clk);
      check(link_bit, "R11", link_bit, 1);
      do_sc(32'h3FFF_FFFC, 1'b1, "R11");
      do_sc(32'h3FFF_FFFC, 1'b0, "R7");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule